// File: doc/BRIEF.md
# Transaction ID compressor with per-ID ordering

This block sits between a request master that tags each transaction with a wide identifier and a downstream port that only carries a 2-bit identifier. On the way down, each request's wide ID is mapped onto one of four slots. A wide ID that already owns a slot reuses it. A new wide ID takes the lowest-numbered idle slot. The slot index is sent downstream as the narrow ID.

Each slot keeps the wide ID it stands for and a count of transactions still in flight under it. When a response comes back, its narrow ID selects the slot, and the wide ID stored there is put back on the response sent to the master. Transactions that share a wide ID always travel under the same narrow ID, so the downstream ordering rule for equal IDs keeps them in issue order. Different wide IDs may complete in any order.

A request is held back when its wide ID would need a fifth slot, or when the channel already has its full budget of transactions in flight. The read path and the write path each get their own independent copy of the slot table and counters. The block only handles identifiers and valid/ready handshakes: no data, address or burst fields.

Top module: `idc_top`

## Requirements
- R1: A request whose wide ID owns no busy slot is sent with narrow ID equal to the lowest-numbered idle slot (a slot is idle when its outstanding count is zero).
- R2: A request whose wide ID matches the ID stored in a busy slot is sent with that slot's narrow ID, so equal wide IDs share one narrow ID while any of them is in flight.
- R3: When all four slots are busy and the request's wide ID matches none of them, the upstream ready and the downstream valid are both low.
- R4: When MAX_OT transactions are outstanding on a channel, its upstream ready and downstream valid are low for every ID, including one that matches a busy slot. This holds even in a cycle where a response completes.
- R5: A response's upstream ID equals the wide ID stored in the slot that its narrow ID selects.
- R6: A completed response decrements its slot's count. On the read channel a response completes only when its last flag is high, and on the write channel every response completes. A slot whose count reaches zero becomes idle and may take a new wide ID.
- R7: A request accepted and a response completed in the same cycle both take effect, including on the same slot. If that slot's count was one, it stays busy and keeps its wide ID.
- R8: The read and write channels keep separate slot tables and outstanding totals, and traffic on one has no effect on the other's outputs.
- R9: A synchronous active-high reset makes every slot idle and sets both outstanding totals to zero.
- R10: Downstream request valid equals upstream valid AND can-accept, and upstream ready equals downstream ready AND can-accept. Response valid, ready and the read last flag pass straight through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_up_req_valid | input | 1 | Read request valid from master |
| rd_up_req_id | input | ID_W | Read request wide ID |
| rd_up_req_ready | output | 1 | Read request ready to master |
| rd_dn_req_valid | output | 1 | Read request valid downstream |
| rd_dn_req_id | output | SW | Read request narrow ID |
| rd_dn_req_ready | input | 1 | Read request ready from downstream |
| rd_dn_rsp_valid | input | 1 | Read response valid from downstream |
| rd_dn_rsp_id | input | SW | Read response narrow ID |
| rd_dn_rsp_last | input | 1 | Read response final beat |
| rd_dn_rsp_ready | output | 1 | Read response ready downstream |
| rd_up_rsp_valid | output | 1 | Read response valid to master |
| rd_up_rsp_id | output | ID_W | Read response restored wide ID |
| rd_up_rsp_last | output | 1 | Read response final beat to master |
| rd_up_rsp_ready | input | 1 | Read response ready from master |
| wr_up_req_valid | input | 1 | Write request valid from master |
| wr_up_req_id | input | ID_W | Write request wide ID |
| wr_up_req_ready | output | 1 | Write request ready to master |
| wr_dn_req_valid | output | 1 | Write request valid downstream |
| wr_dn_req_id | output | SW | Write request narrow ID |
| wr_dn_req_ready | input | 1 | Write request ready from downstream |
| wr_dn_rsp_valid | input | 1 | Write response valid from downstream |
| wr_dn_rsp_id | input | SW | Write response narrow ID |
| wr_dn_rsp_ready | output | 1 | Write response ready downstream |
| wr_up_rsp_valid | output | 1 | Write response valid to master |
| wr_up_rsp_id | output | ID_W | Write response restored wide ID |
| wr_up_rsp_ready | input | 1 | Write response ready from master |

## Verification
The bench builds the block with ID_W = 4, four slots and MAX_OT = 8. The small outstanding budget means the total-limit stall, including its collision with a same-cycle completion, is reached within a few requests. A pool of six wide IDs against four slots makes slot exhaustion and slot reuse after freeing happen many times in a few thousand cycles. Both channels are driven at once with unrelated traffic, and every output of each channel is compared every cycle against an arithmetic slot model kept in the bench.

// File: rtl/idc_pkg.sv
package idc_pkg;
  localparam int unsigned IDC_NARROW_W = 2;
  localparam int unsigned IDC_SLOTS    = 1 << IDC_NARROW_W;

  function automatic int unsigned idc_cnt_w(input int unsigned max_ot);
    return $clog2(max_ot + 1);
  endfunction
endpackage

// File: rtl/idc_lookup.sv
module idc_lookup #(
  parameter int unsigned ID_W  = 8,
  parameter int unsigned SLOTS = 4,
  localparam int unsigned SW   = $clog2(SLOTS)
) (
  input  logic [SLOTS-1:0][ID_W-1:0] tbl_id,
  input  logic [SLOTS-1:0]           busy,
  input  logic [ID_W-1:0]            key,
  output logic                       hit,
  output logic [SW-1:0]              hit_idx,
  output logic                       free_any,
  output logic [SW-1:0]              free_idx
);
  logic [SLOTS-1:0] match;

  for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
    assign match[g] = busy[g] && (tbl_id[g] == key);
  end

  // Descending scans leave the lowest matching index.
  always_comb begin
    hit      = |match;
    free_any = ~&busy;
    hit_idx  = '0;
    free_idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = SW'(i);
      if (!busy[i]) free_idx = SW'(i);
    end
  end
endmodule

// File: rtl/idc_channel.sv
module idc_channel #(
  parameter int unsigned ID_W   = 8,
  parameter int unsigned SLOTS  = 4,
  parameter int unsigned MAX_OT = 64,
  localparam int unsigned SW    = $clog2(SLOTS),
  localparam int unsigned CW    = idc_pkg::idc_cnt_w(MAX_OT)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            up_req_valid,
  input  logic [ID_W-1:0] up_req_id,
  output logic            up_req_ready,
  output logic            dn_req_valid,
  output logic [SW-1:0]   dn_req_id,
  input  logic            dn_req_ready,
  input  logic            dn_rsp_valid,
  input  logic [SW-1:0]   dn_rsp_id,
  input  logic            dn_rsp_last,
  output logic            dn_rsp_ready,
  output logic            up_rsp_valid,
  output logic [ID_W-1:0] up_rsp_id,
  input  logic            up_rsp_ready
);
  logic [SLOTS-1:0][ID_W-1:0] tbl_id;
  logic [CW-1:0]              cnt [SLOTS];
  logic [CW-1:0]              tot;
  logic [SLOTS-1:0]           busy;

  logic          hit, free_any, able, acc, cmp;
  logic [SW-1:0] hit_idx, free_idx, sel;

  for (genvar g = 0; g < SLOTS; g++) begin : g_busy
    assign busy[g] = (cnt[g] != '0);
  end

  idc_lookup #(.ID_W(ID_W), .SLOTS(SLOTS)) u_lookup (
    .tbl_id   (tbl_id),
    .busy     (busy),
    .key      (up_req_id),
    .hit      (hit),
    .hit_idx  (hit_idx),
    .free_any (free_any),
    .free_idx (free_idx)
  );

  assign able = (tot != CW'(MAX_OT)) && (hit || free_any);
  assign sel  = hit ? hit_idx : free_idx;

  assign dn_req_valid = up_req_valid && able;
  assign dn_req_id    = sel;
  assign up_req_ready = dn_req_ready && able;
  assign acc          = up_req_valid && dn_req_ready && able;

  assign up_rsp_valid = dn_rsp_valid;
  assign up_rsp_id    = tbl_id[dn_rsp_id];
  assign dn_rsp_ready = up_rsp_ready;
  assign cmp          = dn_rsp_valid && up_rsp_ready && dn_rsp_last;

  // Table written only on allocation; no reset needed since busy gates use.
  always_ff @(posedge clk) begin
    if (acc && !hit) tbl_id[sel] <= up_req_id;
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_cnt
    logic inc, dec;
    assign inc = acc && (sel == SW'(g));
    assign dec = cmp && (dn_rsp_id == SW'(g));
    always_ff @(posedge clk) begin
      if (rst) cnt[g] <= '0;
      else begin
        case ({inc, dec})
          2'b10:   cnt[g] <= cnt[g] + 1'b1;
          2'b01:   cnt[g] <= cnt[g] - 1'b1;
          default: cnt[g] <= cnt[g];
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) tot <= '0;
    else begin
      case ({acc, cmp})
        2'b10:   tot <= tot + 1'b1;
        2'b01:   tot <= tot - 1'b1;
        default: tot <= tot;
      endcase
    end
  end
endmodule

// File: rtl/idc_top.sv
module idc_top #(
  parameter int unsigned ID_W    = 8,
  parameter int unsigned N_SLOTS = idc_pkg::IDC_SLOTS,
  parameter int unsigned MAX_OT  = 64,
  localparam int unsigned SW     = $clog2(N_SLOTS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_up_req_valid,
  input  logic [ID_W-1:0] rd_up_req_id,
  output logic            rd_up_req_ready,
  output logic            rd_dn_req_valid,
  output logic [SW-1:0]   rd_dn_req_id,
  input  logic            rd_dn_req_ready,
  input  logic            rd_dn_rsp_valid,
  input  logic [SW-1:0]   rd_dn_rsp_id,
  input  logic            rd_dn_rsp_last,
  output logic            rd_dn_rsp_ready,
  output logic            rd_up_rsp_valid,
  output logic [ID_W-1:0] rd_up_rsp_id,
  output logic            rd_up_rsp_last,
  input  logic            rd_up_rsp_ready,
  input  logic            wr_up_req_valid,
  input  logic [ID_W-1:0] wr_up_req_id,
  output logic            wr_up_req_ready,
  output logic            wr_dn_req_valid,
  output logic [SW-1:0]   wr_dn_req_id,
  input  logic            wr_dn_req_ready,
  input  logic            wr_dn_rsp_valid,
  input  logic [SW-1:0]   wr_dn_rsp_id,
  output logic            wr_dn_rsp_ready,
  output logic            wr_up_rsp_valid,
  output logic [ID_W-1:0] wr_up_rsp_id,
  input  logic            wr_up_rsp_ready
);
  assign rd_up_rsp_last = rd_dn_rsp_last;

  idc_channel #(.ID_W(ID_W), .SLOTS(N_SLOTS), .MAX_OT(MAX_OT)) u_rd (
    .clk          (clk),
    .rst          (rst),
    .up_req_valid (rd_up_req_valid),
    .up_req_id    (rd_up_req_id),
    .up_req_ready (rd_up_req_ready),
    .dn_req_valid (rd_dn_req_valid),
    .dn_req_id    (rd_dn_req_id),
    .dn_req_ready (rd_dn_req_ready),
    .dn_rsp_valid (rd_dn_rsp_valid),
    .dn_rsp_id    (rd_dn_rsp_id),
    .dn_rsp_last  (rd_dn_rsp_last),
    .dn_rsp_ready (rd_dn_rsp_ready),
    .up_rsp_valid (rd_up_rsp_valid),
    .up_rsp_id    (rd_up_rsp_id),
    .up_rsp_ready (rd_up_rsp_ready)
  );

  // Write responses are single-beat: every one completes.
  idc_channel #(.ID_W(ID_W), .SLOTS(N_SLOTS), .MAX_OT(MAX_OT)) u_wr (
    .clk          (clk),
    .rst          (rst),
    .up_req_valid (wr_up_req_valid),
    .up_req_id    (wr_up_req_id),
    .up_req_ready (wr_up_req_ready),
    .dn_req_valid (wr_dn_req_valid),
    .dn_req_id    (wr_dn_req_id),
    .dn_req_ready (wr_dn_req_ready),
    .dn_rsp_valid (wr_dn_rsp_valid),
    .dn_rsp_id    (wr_dn_rsp_id),
    .dn_rsp_last  (1'b1),
    .dn_rsp_ready (wr_dn_rsp_ready),
    .up_rsp_valid (wr_up_rsp_valid),
    .up_rsp_id    (wr_up_rsp_id),
    .up_rsp_ready (wr_up_rsp_ready)
  );
endmodule

// File: rtl/idc_chk.sv
module idc_chk #(
  parameter int unsigned ID_W   = 8,
  parameter int unsigned SLOTS  = 4,
  parameter int unsigned MAX_OT = 64,
  localparam int unsigned SW    = $clog2(SLOTS),
  localparam int unsigned CW    = idc_pkg::idc_cnt_w(MAX_OT)
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       up_req_valid,
  input logic [ID_W-1:0]            up_req_id,
  input logic                       up_req_ready,
  input logic                       dn_req_valid,
  input logic [SW-1:0]              dn_req_id,
  input logic                       dn_req_ready,
  input logic [SLOTS-1:0][ID_W-1:0] tbl_id,
  input logic [SLOTS-1:0]           busy,
  input logic [CW-1:0]              tot
);
  assert_limit_stall_R4: assert property (@(posedge clk) disable iff (rst)
    (tot == CW'(MAX_OT)) |-> (!up_req_ready && !dn_req_valid));

  assert_total_bound_R4: assert property (@(posedge clk) disable iff (rst)
    tot <= CW'(MAX_OT));

  assert_full_only_reuse_R3: assert property (@(posedge clk) disable iff (rst)
    ((&busy) && dn_req_valid) |-> (tbl_id[dn_req_id] == up_req_id));

  assert_busy_slot_reuse_R2: assert property (@(posedge clk) disable iff (rst)
    (dn_req_valid && busy[dn_req_id]) |-> (tbl_id[dn_req_id] == up_req_id));

  assert_slot_held_after_accept_R1: assert property (@(posedge clk) disable iff (rst)
    (dn_req_valid && dn_req_ready) |=> busy[$past(dn_req_id)]);

  assert_valid_needs_source_R10: assert property (@(posedge clk) disable iff (rst)
    dn_req_valid |-> up_req_valid);

  assert_reset_clears_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ((tot == '0) && (busy == '0)));
endmodule

bind idc_channel idc_chk #(.ID_W(ID_W), .SLOTS(SLOTS), .MAX_OT(MAX_OT)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .up_req_valid (up_req_valid),
  .up_req_id    (up_req_id),
  .up_req_ready (up_req_ready),
  .dn_req_valid (dn_req_valid),
  .dn_req_id    (dn_req_id),
  .dn_req_ready (dn_req_ready),
  .tbl_id       (tbl_id),
  .busy         (busy),
  .tot          (tot)
);

// File: tb/idc_top_tb.sv
`timescale 1ns/1ps
module idc_top_tb;
  localparam int ID_W = 4;
  localparam int NS   = 4;
  localparam int MOT  = 8;
  localparam int SW   = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;
  logic rst;

  logic            rq_v [2];
  logic [ID_W-1:0] rq_id [2];
  logic            dq_r [2];
  logic            rs_v [2];
  logic [SW-1:0]   rs_id [2];
  logic            rs_l;
  logic            ur_r [2];

  logic            o_ready [2];
  logic            o_dv [2];
  logic [SW-1:0]   o_did [2];
  logic            o_rsr [2];
  logic            o_uv [2];
  logic [ID_W-1:0] o_uid [2];
  logic            o_ulast;

  idc_top #(.ID_W(ID_W), .N_SLOTS(NS), .MAX_OT(MOT)) u_dut (
    .clk(clk), .rst(rst),
    .rd_up_req_valid(rq_v[0]), .rd_up_req_id(rq_id[0]), .rd_up_req_ready(o_ready[0]),
    .rd_dn_req_valid(o_dv[0]), .rd_dn_req_id(o_did[0]), .rd_dn_req_ready(dq_r[0]),
    .rd_dn_rsp_valid(rs_v[0]), .rd_dn_rsp_id(rs_id[0]), .rd_dn_rsp_last(rs_l),
    .rd_dn_rsp_ready(o_rsr[0]), .rd_up_rsp_valid(o_uv[0]), .rd_up_rsp_id(o_uid[0]),
    .rd_up_rsp_last(o_ulast), .rd_up_rsp_ready(ur_r[0]),
    .wr_up_req_valid(rq_v[1]), .wr_up_req_id(rq_id[1]), .wr_up_req_ready(o_ready[1]),
    .wr_dn_req_valid(o_dv[1]), .wr_dn_req_id(o_did[1]), .wr_dn_req_ready(dq_r[1]),
    .wr_dn_rsp_valid(rs_v[1]), .wr_dn_rsp_id(rs_id[1]),
    .wr_dn_rsp_ready(o_rsr[1]), .wr_up_rsp_valid(o_uv[1]), .wr_up_rsp_id(o_uid[1]),
    .wr_up_rsp_ready(ur_r[1])
  );

  int m_id [2][NS];
  int m_cnt [2][NS];
  int m_tot [2];
  bit p_acc [2];
  bit p_new [2];
  bit p_cmp [2];
  int p_sel [2];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int c = 0; c < 2; c++) begin
      m_tot[c] = 0;
      for (int s = 0; s < NS; s++) begin m_cnt[c][s] = 0; m_id[c][s] = 0; end
    end
  endtask

  task automatic evaluate(input string tag);
    for (int c = 0; c < 2; c++) begin
      bit hit, fr, full, able, ex_rdy, ex_dv;
      int hidx, fidx, sel;
      string why;
      hit = 0; fr = 0; hidx = 0; fidx = 0;
      for (int s = NS - 1; s >= 0; s--) begin
        if (m_cnt[c][s] > 0 && m_id[c][s] == int'(rq_id[c])) begin hit = 1; hidx = s; end
        if (m_cnt[c][s] == 0) begin fr = 1; fidx = s; end
      end
      full   = (m_tot[c] == MOT);
      able   = !full && (hit || fr);
      sel    = hit ? hidx : fidx;
      ex_rdy = dq_r[c] && able;
      ex_dv  = rq_v[c] && able;
      why    = full ? "R4" : (!(hit || fr) ? "R3" : "R10");
      chk(o_ready[c] == ex_rdy, $sformatf("%s %s ch%0d req ready", tag, why, c), o_ready[c], ex_rdy);
      chk(o_dv[c] == ex_dv, $sformatf("%s %s ch%0d dn valid", tag, why, c), o_dv[c], ex_dv);
      if (ex_dv)
        chk(int'(o_did[c]) == sel, $sformatf("%s %s ch%0d narrow id", tag, hit ? "R2" : "R1", c),
            o_did[c], sel);
      chk(o_rsr[c] == ur_r[c], $sformatf("%s R10 ch%0d rsp ready", tag, c), o_rsr[c], ur_r[c]);
      chk(o_uv[c] == rs_v[c], $sformatf("%s R10 ch%0d rsp valid", tag, c), o_uv[c], rs_v[c]);
      if (rs_v[c])
        chk(int'(o_uid[c]) == m_id[c][rs_id[c]], $sformatf("%s R5 ch%0d restored id", tag, c),
            o_uid[c], m_id[c][rs_id[c]]);
      p_acc[c] = rq_v[c] && dq_r[c] && able;
      p_new[c] = !hit;
      p_sel[c] = sel;
      p_cmp[c] = rs_v[c] && ur_r[c] && (c == 1 || rs_l);
    end
    chk(o_ulast == rs_l, {tag, " R10 rd last"}, o_ulast, rs_l);
  endtask

  task automatic commit();
    for (int c = 0; c < 2; c++) begin
      if (p_acc[c]) begin
        if (p_new[c]) m_id[c][p_sel[c]] = int'(rq_id[c]);
        m_cnt[c][p_sel[c]]++;
        m_tot[c]++;
      end
      if (p_cmp[c]) begin
        m_cnt[c][rs_id[c]]--;
        m_tot[c]--;
      end
    end
  endtask

  task automatic cycle(input string tag);
    #1;
    evaluate(tag);
    @(posedge clk);
    if (!rst) commit();
    @(negedge clk);
  endtask

  task automatic idle();
    for (int c = 0; c < 2; c++) begin
      rq_v[c] = 0; rq_id[c] = '0; dq_r[c] = 1; rs_v[c] = 0; rs_id[c] = '0; ur_r[c] = 1;
    end
    rs_l = 1;
  endtask

  task automatic issue(input int c, input int id, input string tag);
    rq_v[c] = 1; rq_id[c] = ID_W'(id);
    cycle(tag);
    rq_v[c] = 0;
  endtask

  task automatic complete(input int c, input int slot, input bit last, input string tag);
    rs_v[c] = 1; rs_id[c] = SW'(slot); rs_l = last;
    cycle(tag);
    rs_v[c] = 0; rs_l = 1;
  endtask

  task automatic drain();
    for (int c = 0; c < 2; c++)
      for (int s = 0; s < NS; s++)
        while (m_cnt[c][s] > 0) complete(c, s, 1'b1, "drain R6");
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 0, 1);
      report();
    end
  end

  initial begin
    model_clear();
    idle();
    rst = 1;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    cycle("R9 reset state");

    // R1/R2/R3: fill read slots with ids 3,3,5,7,9; id 11 must stall.
    issue(0, 3, "R1 first");
    issue(0, 3, "R2 reuse");
    issue(0, 5, "R1 second");
    issue(0, 7, "R1 third");
    issue(0, 9, "R1 fourth");
    issue(0, 11, "R3 no slot");
    issue(0, 7, "R2 reuse when full");
    // R8: write channel unaffected by the full read table.
    issue(1, 11, "R8 write independent");
    chk(m_cnt[1][0] == 1, "R8 write slot model", m_cnt[1][0], 1);

    // R6: non-last beat leaves slot 1 busy; last beat frees it.
    complete(0, 1, 1'b0, "R6 non-last");
    issue(0, 12, "R6 still full");
    complete(0, 1, 1'b1, "R6 last beat");
    issue(0, 12, "R6 freed slot reused");

    // R7: same-cycle accept and completion on slot 1 (count 1).
    rq_v[0] = 1; rq_id[0] = ID_W'(12); rs_v[0] = 1; rs_id[0] = SW'(1); rs_l = 1;
    cycle("R7 same slot");
    rq_v[0] = 0; rs_v[0] = 0;
    chk(m_cnt[0][1] == 1, "R7 slot count", m_cnt[0][1], 1);
    complete(0, 1, 1'b1, "R7 final completion");
    issue(0, 13, "R7 slot free after");
    // Write channel: accept on slot 0 and complete slot 0 together.
    rq_v[1] = 1; rq_id[1] = ID_W'(11); rs_v[1] = 1; rs_id[1] = SW'(0);
    cycle("R7 write same slot");
    rq_v[1] = 0; rs_v[1] = 0;
    drain();

    // R4: single id up to MAX_OT outstanding.
    for (int k = 0; k < MOT; k++) issue(0, 6, "R4 fill");
    issue(0, 6, "R4 limit same id");
    issue(0, 2, "R4 limit new id");
    rq_v[0] = 1; rq_id[0] = ID_W'(6); rs_v[0] = 1; rs_id[0] = SW'(0); rs_l = 1;
    cycle("R4 limit with completion");
    rq_v[0] = 0; rs_v[0] = 0;
    issue(0, 6, "R4 below limit");
    drain();

    // Sweep: both channels, six ids over four slots.
    for (int n = 0; n < 4000; n++) begin
      for (int c = 0; c < 2; c++) begin
        int s;
        rq_v[c]  = ($urandom_range(0, 2) != 0);
        rq_id[c] = ID_W'($urandom_range(0, 5) + 8 * c);
        dq_r[c]  = ($urandom_range(0, 7) != 0);
        ur_r[c]  = ($urandom_range(0, 7) != 0);
        s = $urandom_range(0, NS - 1);
        rs_id[c] = SW'(s);
        rs_v[c]  = (m_cnt[c][s] > 0) && ($urandom_range(0, 2) != 0);
      end
      rs_l = ($urandom_range(0, 3) != 0);
      cycle("sweep");
    end

    // R9: reset in the middle of traffic.
    idle();
    issue(0, 4, "R9 pre");
    issue(1, 4, "R9 pre");
    rst = 1;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    model_clear();
    issue(0, 14, "R9 after reset slot0");
    issue(1, 15, "R9 after reset slot0");

    done = 1;
    report();
  end
endmodule